// File: doc/BRIEF.md
# Token-Ring Polling Readout Manager

This block lets a row of per-channel event buffers share one digital output bus and one analog output bus. It watches the OR of all channel not-empty flags. Once that condition has held for a fixed launch delay, it starts a one-hot token at channel 0. The token then steps one channel per polling slot, where a slot is a fixed number of main-clock cycles.

When the token reaches a channel that holds data, that channel gets a one-cycle read strobe at the start of its slot. The word at the head of its buffer is captured and sent out on the digital bus as a burst of narrow packets, with a valid flag. For the same cycles, the analog select for that channel is raised so that its stored sample drives the analog bus. An empty channel gets no strobe, but the token still spends a full slot there.

When the token leaves the last channel, it returns to channel 0 if any buffer still holds data. Otherwise it parks, and the launch delay must elapse again before the next sweep. The buffers and the analog multiplexer are outside this block.

Top module: `tr_poll_mgr`

## Requirements
- R1: While reset is asserted, `token`, `chan_rd`, `ana_sel`, `bus_pkt` and `bus_valid` are all zero.
- R2: A sweep starts only after the not-empty OR has been sampled high on LAUNCH_DLY consecutive rising edges while parked. The sweep begins after the last of those edges. If the OR is sampled low, the count restarts from zero.
- R3: During a sweep, `token` is one-hot, with bit c standing for channel c. It starts at channel 0 and moves to channel c+1 every SLOT_CYC cycles, so a full sweep takes NCH*SLOT_CYC cycles.
- R4: In the first cycle of a slot, `chan_rd` holds the token bit if that channel's not-empty flag is high. Otherwise it is zero. It is zero in every other cycle of the slot, and the dwell time does not depend on whether the channel had data.
- R5: At most one bit of `chan_rd` is high in any cycle.
- R6: On the cycle after a strobe, `bus_valid` rises and stays high for exactly NPKT cycles. Over those cycles, `bus_pkt` carries the captured word most-significant packet first: packet p is bits [WORD_W-1-p*PKT_W -: PKT_W].
- R7: While `bus_valid` is low, `bus_pkt` holds its last value.
- R8: `ana_sel` is one-hot on the channel that was read while `bus_valid` is high. It is zero while `bus_valid` is low.
- R9: At the end of the last channel's slot, the token returns to channel 0 on the next cycle if any not-empty flag was high. Otherwise `token` goes to zero and the R2 delay applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_nempty | input | NCH | Per-channel buffer not-empty flags |
| chan_word | input | NCH*WORD_W | Per-channel head-of-buffer words, channel c at bits [c*WORD_W +: WORD_W] |
| chan_rd | output | NCH | Per-channel read strobe (pops one entry) |
| token | output | NCH | One-hot polling token, zero while parked |
| ana_sel | output | NCH | One-hot analog bus select for the channel being output |
| bus_pkt | output | PKT_W | Digital bus packet |
| bus_valid | output | 1 | Marks `bus_pkt` as carrying read data |

## Verification
The bench drives the launch delay to its edge by emptying the only busy channel partway through the count. A design that fails to restart the count would launch early. It fills every channel twice, so that packet bursts from neighbouring slots run back to back; an off-by-one in the burst length would either overlap bursts or leave a gap. Data is pushed into a channel that the token has already passed and into one it has not yet reached. This exposes a design that parks at the end of a sweep when it should wrap, or that reads a channel before its own slot. Single-channel sweeps on each channel in turn confirm that empty slots get full dwell and that only the occupied slot strobes.

// File: rtl/tr_pkg.sv
package tr_pkg;

  typedef enum logic {
    RING_PARK = 1'b0,
    RING_RUN  = 1'b1
  } ring_state_e;

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/tr_launch.sv
module tr_launch
  import tr_pkg::*;
#(
  parameter int LAUNCH_DLY = 20,
  localparam int CW = safe_clog2(LAUNCH_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic any_ne,
  output logic fire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LAUNCH_DLY - 1));
  assign fire   = armed && any_ne && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!armed || !any_ne) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tr_ring.sv
module tr_ring
  import tr_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int SLOT_CYC = 4,
  localparam int PW = safe_clog2(SLOT_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           any_ne,
  output logic           parked,
  output logic           slot_first,
  output logic [NCH-1:0] token
);

  ring_state_e    st_q, st_d;
  logic [NCH-1:0] tok_q, tok_d;
  logic [PW-1:0]  ph_q, ph_d;
  logic           ph_last;

  assign ph_last    = (ph_q == PW'(SLOT_CYC - 1));
  assign parked     = (st_q == RING_PARK);
  assign slot_first = (st_q == RING_RUN) && (ph_q == '0);
  assign token      = tok_q;

  always_comb begin
    st_d  = st_q;
    tok_d = tok_q;
    ph_d  = ph_q;
    unique case (st_q)
      RING_PARK: begin
        if (fire) begin
          st_d  = RING_RUN;
          tok_d = NCH'(1);
          ph_d  = '0;
        end
      end
      RING_RUN: begin
        if (ph_last) begin
          ph_d = '0;
          if (tok_q[NCH-1]) begin
            if (any_ne) begin
              tok_d = NCH'(1);
            end else begin
              st_d  = RING_PARK;
              tok_d = '0;
            end
          end else begin
            tok_d = tok_q << 1;
          end
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end
      default: begin
        st_d  = RING_PARK;
        tok_d = '0;
        ph_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RING_PARK;
      tok_q <= '0;
      ph_q  <= '0;
    end else begin
      st_q  <= st_d;
      tok_q <= tok_d;
      ph_q  <= ph_d;
    end
  end

endmodule

// File: rtl/tr_serial.sv
module tr_serial
  import tr_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int PKT_W = 6,
  parameter int NPKT  = 4,
  localparam int WORD_W = NPKT * PKT_W,
  localparam int LW     = safe_clog2(NPKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [NCH-1:0]    cap_sel,
  input  logic [WORD_W-1:0] word,
  output logic [PKT_W-1:0]  pkt,
  output logic              valid,
  output logic [NCH-1:0]    sel
);

  logic [PKT_W-1:0]  pkt_q, pkt_d;
  logic [WORD_W-1:0] rest_q, rest_d;
  logic [LW-1:0]     left_q, left_d;
  logic              vld_q, vld_d;
  logic [NCH-1:0]    sel_q, sel_d;

  always_comb begin
    pkt_d  = pkt_q;
    rest_d = rest_q;
    left_d = left_q;
    vld_d  = vld_q;
    sel_d  = sel_q;
    if (cap) begin
      pkt_d  = word[WORD_W-1 -: PKT_W];
      rest_d = word << PKT_W;
      left_d = LW'(NPKT - 1);
      vld_d  = 1'b1;
      sel_d  = cap_sel;
    end else if (left_q != '0) begin
      pkt_d  = rest_q[WORD_W-1 -: PKT_W];
      rest_d = rest_q << PKT_W;
      left_d = left_q - LW'(1);
    end else if (vld_q) begin
      vld_d = 1'b0;
      sel_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q  <= '0;
      rest_q <= '0;
      left_q <= '0;
      vld_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      pkt_q  <= pkt_d;
      rest_q <= rest_d;
      left_q <= left_d;
      vld_q  <= vld_d;
      sel_q  <= sel_d;
    end
  end

  assign pkt   = pkt_q;
  assign valid = vld_q;
  assign sel   = sel_q;

endmodule

// File: rtl/tr_poll_mgr.sv
module tr_poll_mgr
  import tr_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int SLOT_CYC   = 4,
  parameter int LAUNCH_DLY = 20,
  parameter int PKT_W      = 6,
  parameter int NPKT       = 4,
  localparam int WORD_W    = NPKT * PKT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        chan_nempty,
  input  logic [NCH*WORD_W-1:0] chan_word,
  output logic [NCH-1:0]        chan_rd,
  output logic [NCH-1:0]        token,
  output logic [NCH-1:0]        ana_sel,
  output logic [PKT_W-1:0]      bus_pkt,
  output logic                  bus_valid
);

  logic           any_ne;
  logic           parked;
  logic           fire;
  logic           slot_first;
  logic           cap;
  logic [NCH-1:0] tok;
  logic [NCH-1:0] rd;
  logic [WORD_W-1:0] masked [NCH];
  logic [WORD_W-1:0] sel_word;

  assign any_ne = |chan_nempty;

  tr_launch #(.LAUNCH_DLY(LAUNCH_DLY)) u_launch (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (parked),
    .any_ne (any_ne),
    .fire   (fire)
  );

  tr_ring #(.NCH(NCH), .SLOT_CYC(SLOT_CYC)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .any_ne     (any_ne),
    .parked     (parked),
    .slot_first (slot_first),
    .token      (tok)
  );

  assign rd  = tok & chan_nempty & {NCH{slot_first}};
  assign cap = |rd;

  for (genvar c = 0; c < NCH; c++) begin : g_mux
    assign masked[c] = chan_word[c*WORD_W +: WORD_W] & {WORD_W{rd[c]}};
  end

  always_comb begin
    sel_word = '0;
    for (int c = 0; c < NCH; c++) begin
      sel_word = sel_word | masked[c];
    end
  end

  tr_serial #(.NCH(NCH), .PKT_W(PKT_W), .NPKT(NPKT)) u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .cap_sel (rd),
    .word    (sel_word),
    .pkt     (bus_pkt),
    .valid   (bus_valid),
    .sel     (ana_sel)
  );

  assign chan_rd = rd;
  assign token   = tok;

endmodule

// File: rtl/tr_poll_chk.sv
module tr_poll_chk #(
  parameter int NCH   = 16,
  parameter int PKT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   chan_nempty,
  input logic [NCH-1:0]   chan_rd,
  input logic [NCH-1:0]   token,
  input logic [NCH-1:0]   ana_sel,
  input logic [PKT_W-1:0] bus_pkt,
  input logic             bus_valid
);

  assert_rd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_rd));

  assert_token_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token));

  assert_token_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (token != '0 && $past(token) != '0 && token != $past(token)) |->
      (token == ($past(token) << 1)) || (token == NCH'(1) && $past(token[NCH-1])));

  assert_launch_ch0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(token) == '0 && token != '0) |-> token == NCH'(1));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rd != '0) |=> (chan_rd == '0));

  assert_strobe_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rd != '0) |=> bus_valid);

  assert_pkt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> $stable(bus_pkt));

  assert_sel_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $onehot(ana_sel));

  assert_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (ana_sel == '0));

  assert_park_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(token) != '0 && token == '0) |-> ($past(token[NCH-1]) && $past(chan_nempty) == '0));

endmodule

bind tr_poll_mgr tr_poll_chk #(.NCH(NCH), .PKT_W(PKT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_nempty (chan_nempty),
  .chan_rd     (chan_rd),
  .token       (token),
  .ana_sel     (ana_sel),
  .bus_pkt     (bus_pkt),
  .bus_valid   (bus_valid)
);

// File: tb/tr_poll_mgr_tb.sv
module tr_poll_mgr_tb;

  localparam int NCH  = 16;
  localparam int SLOT = 4;
  localparam int DLY  = 20;
  localparam int PW   = 6;
  localparam int NPKT = 4;
  localparam int WW   = NPKT * PW;
  localparam int FD   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]    chan_nempty;
  logic [NCH*WW-1:0] chan_word;
  logic [NCH-1:0]    chan_rd, token, ana_sel;
  logic [PW-1:0]     bus_pkt;
  logic              bus_valid;

  always #2.5 clk = ~clk;

  tr_poll_mgr #(.NCH(NCH), .SLOT_CYC(SLOT), .LAUNCH_DLY(DLY), .PKT_W(PW), .NPKT(NPKT)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_nempty(chan_nempty), .chan_word(chan_word),
    .chan_rd(chan_rd), .token(token), .ana_sel(ana_sel), .bus_pkt(bus_pkt), .bus_valid(bus_valid)
  );

  // channel buffer model
  logic [WW-1:0]  fmem [NCH][FD];
  int             fcnt [NCH];
  int             frd  [NCH];
  int             seq;
  logic [NCH-1:0] push_mask, flush_mask;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chan_nempty[c]          = (fcnt[c] != 0);
      chan_word[c*WW +: WW]   = fmem[c][frd[c]];
    end
  end

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (flush_mask[c]) begin
        fcnt[c] <= 0;
      end else begin
        fcnt[c] <= fcnt[c] - ((chan_rd[c] && fcnt[c] != 0) ? 1 : 0) + (push_mask[c] ? 1 : 0);
      end
      if (chan_rd[c] && fcnt[c] != 0) frd[c] <= (frd[c] + 1) % FD;
      if (push_mask[c]) fmem[c][(frd[c] + fcnt[c]) % FD] <= WW'((seq * 40503) ^ (c << 19) ^ 24'h5A5A5A);
    end
    if (push_mask != '0) seq <= seq + 1;
  end

  // reference and comparison
  int vectors = 0;
  int fails   = 0;
  int r_idle, r_cnt, r_slot, r_ph, win, wch, parked_sweep, wrapped;
  logic [WW-1:0]  wword;
  logic [PW-1:0]  last_pkt;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [NCH-1:0] e_tok, e_rd, e_sel;
    logic [PW-1:0]  e_pkt;
    logic           e_v;
    int any;
    string ttag;
    if (!rst_n) begin
      r_idle = 1; r_cnt = 0; r_slot = 0; r_ph = 0; win = 0; wch = 0;
      parked_sweep = 0; wrapped = 0; wword = '0; last_pkt = '0;
      cmp("R1", "token", 32'(token), 0);
      cmp("R1", "chan_rd", 32'(chan_rd), 0);
      cmp("R1", "ana_sel", 32'(ana_sel), 0);
      cmp("R1", "bus_pkt", 32'(bus_pkt), 0);
      cmp("R1", "bus_valid", 32'(bus_valid), 0);
    end else begin
      any = 0;
      for (int c = 0; c < NCH; c++) if (fcnt[c] != 0) any = 1;
      e_tok = r_idle ? '0 : (NCH'(1) << r_slot);
      e_rd  = (!r_idle && r_ph == 0 && fcnt[r_slot] != 0) ? (NCH'(1) << r_slot) : '0;
      if (win > 0) begin
        e_v   = 1'b1;
        e_pkt = wword[WW-1-PW*(NPKT-win) -: PW];
        e_sel = NCH'(1) << wch;
      end else begin
        e_v   = 1'b0;
        e_pkt = last_pkt;
        e_sel = '0;
      end
      if (r_idle) ttag = parked_sweep ? "R9" : "R2";
      else        ttag = wrapped ? "R9" : "R3";
      cmp(ttag, "token", 32'(token), 32'(e_tok));
      cmp("R4", "chan_rd", 32'(chan_rd), 32'(e_rd));
      cmp("R5", "rd_ones", 32'($countones(chan_rd) <= 1), 1);
      cmp("R6", "bus_valid", 32'(bus_valid), 32'(e_v));
      cmp(e_v ? "R6" : "R7", "bus_pkt", 32'(bus_pkt), 32'(e_pkt));
      cmp("R8", "ana_sel", 32'(ana_sel), 32'(e_sel));
      // next-cycle reference
      if (win > 0) begin last_pkt = e_pkt; win--; end
      if (e_rd != '0) begin win = NPKT; wch = r_slot; wword = fmem[r_slot][frd[r_slot]]; end
      if (r_idle != 0) begin
        if (any == 0) r_cnt = 0;
        else if (r_cnt == DLY - 1) begin
          r_idle = 0; r_cnt = 0; r_slot = 0; r_ph = 0; parked_sweep = 0; wrapped = 0;
        end else r_cnt++;
      end else if (r_ph == SLOT - 1) begin
        r_ph = 0;
        wrapped = 0;
        if (r_slot == NCH - 1) begin
          if (any != 0) begin r_slot = 0; wrapped = 1; end
          else begin r_idle = 1; parked_sweep = 1; end
        end else r_slot++;
      end else r_ph++;
    end
  end

  // stimulus
  int to_fail = 0;

  task automatic push(input logic [NCH-1:0] m);
    @(negedge clk); push_mask = m;
    @(negedge clk); push_mask = '0;
  endtask

  task automatic flush(input logic [NCH-1:0] m);
    @(negedge clk); flush_mask = m;
    @(negedge clk); flush_mask = '0;
  endtask

  function automatic bit quiet();
    int busy = 0;
    for (int c = 0; c < NCH; c++) if (fcnt[c] != 0) busy = 1;
    return (r_idle != 0) && (win == 0) && (busy == 0);
  endfunction

  task automatic wait_quiet();
    int g = 0;
    do begin @(negedge clk); g++; end while (!quiet() && g < 5000);
    if (g >= 5000) begin to_fail++; $display("FAIL R9 no return to park act=busy exp=parked"); end
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails + to_fail + 1);
    $finish;
  end

  initial begin
    seq = 1;
    push_mask = '0; flush_mask = '0;
    for (int c = 0; c < NCH; c++) begin
      fcnt[c] = 0; frd[c] = 0;
      for (int d = 0; d < FD; d++) fmem[c][d] = '0;
    end
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R2 R3 R4 R6 R9: sparse channels, one with two entries -> second sweep
    push(NCH'(1) << 3 | NCH'(1) << 10 | NCH'(1) << 15);
    push(NCH'(1) << 10);
    wait_quiet();
    // R2: buffer empties before the delay ends, count restarts
    push(NCH'(1) << 7);
    repeat (8) @(negedge clk);
    flush(NCH'(1) << 7);
    repeat (4) @(negedge clk);
    push(NCH'(1) | NCH'(1) << 7);
    wait_quiet();
    // R6 R7 R8: all channels, two entries each, back-to-back bursts
    push('1);
    push('1);
    wait_quiet();
    // R9: entries behind and ahead of the token mid-sweep
    push(NCH'(1) << 9);
    while (!(r_idle == 0 && r_slot == 12)) @(negedge clk);
    push(NCH'(1) << 4 | NCH'(1) << 13);
    wait_quiet();
    // R4: each channel alone, full dwell on empty slots
    for (int c = 0; c < NCH; c++) begin
      push(NCH'(1) << c);
      wait_quiet();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails + to_fail);
    $finish;
  end

endmodule